// File: doc/BRIEF.md
# NAND Page Hamming Parity Accumulator

This block sits beside a byte-wide NAND Flash bus controller and listens to the command, address and data strobes it drives. A read-type command byte (0x00) or a program-type command byte (0x80), followed by at least one address cycle, arms the block. The block then clears its results and counts data bytes from the page boundary. For every sector it builds a single-error-correcting, double-error-detecting Hamming parity word. A sector is the whole main area, 256 bytes or 512 bytes, chosen by a granularity input. Each word is written into its own result slot.

When the last byte of the main area has been taken, the valid flag rises and the slots freeze. Bytes that follow in the spare area have no effect on them. The slots stay frozen until the next arming sequence or a synchronous clear. Software reads the words and places them in the spare area. Comparison against stored parity and the actual bit correction are done outside this block.

Top module: `nand_hamming_acc`

## Requirements
- R1: While reset is asserted and after its release, `parity_valid` is 0 and every slot of `parity_flat` is zero.
- R2: A `cmd_stb` cycle with `bus_data` 0x00 or 0x80, followed by an `addr_stb` cycle, starts a page. From the cycle after that first address strobe, `parity_valid` is 0, all slots are zero and the byte count restarts at 0. Any other command byte followed by address cycles clears nothing.
- R3: Slot bits [5:0] hold column parity. Bit 2j+1 is the XOR of all data bits of the sector whose bit position has bit j set, for j = 0,1,2. Bit 2j is the XOR of the data bits whose position has bit j clear.
- R4: Slot bit 6+2k+1 is the XOR of the byte parities (XOR of the 8 bits) of the sector bytes whose in-sector index has bit k set. Bit 6+2k uses the bytes whose index has bit k clear. This holds for k below log2 of the sector size. All higher slot bits are zero.
- R5: `gran_cfg` selects the sector: 1 gives 256 bytes, 2 gives 512 bytes, and 0 or 3 gives the whole main area. Sector n, which covers bytes n*S to n*S+S-1, is reported in slot n, at bits [n*30 +: 30].
- R6: `page_cfg` values 0, 1, 2 and 3 select pages of 528, 1056, 2112 and 4224 bytes. Their main areas are 512, 1024, 2048 and 4096 bytes.
- R7: `parity_valid` rises in the cycle after the edge that takes the last main-area byte. It is 0 before that edge. From that cycle on, all used slots hold their final values.
- R8: Once valid, the slots and the flag do not change on further data bytes (the spare area). They also do not change on a start command byte that has no following address cycle. They only change at the next R2 start or at R10.
- R9: Slots at or above the used count (main size divided by sector size) read zero.
- R10: A high `clr` at a clock edge makes all slots zero and `parity_valid` 0 from the next cycle. Data bytes are ignored until the next R2 start.
- R11: `page_cfg` and `gran_cfg` are sampled at the starting address cycle. Changes while a page is in progress have no effect on that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of slots and valid flag |
| cmd_stb | input | 1 | Command byte present on bus_data |
| addr_stb | input | 1 | Address byte present on bus_data |
| data_stb | input | 1 | Data byte present on bus_data |
| bus_data | input | 8 | Snooped NAND bus byte |
| page_cfg | input | 2 | Page size select (512 << page_cfg main bytes) |
| gran_cfg | input | 2 | Sector granularity select |
| parity_flat | output | 480 | 16 slots of 30-bit parity words, slot n at [n*30 +: 30] |
| parity_valid | output | 1 | Results complete and locked |

## Verification
A byte counter that is wrong by even one position moves the flag edge. It also moves the sector boundary, so the words of two neighbouring slots are corrupted at once. Both effects are visible in the cycle that follows the final main-area byte. A working accumulator that is not reset at a sector boundary leaks the previous sector's parity into the next slot. A line-parity index error flips matched pairs of line bits in the affected word. A missing lock or arming fault shows up as slot values that move during spare-area bytes or stray commands. These faults are caught at the next check of the ports.

// File: rtl/nha_pkg.sv
package nha_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_ACC  = 2'd2,
    ST_LOCK = 2'd3
  } nha_state_e;

  typedef enum logic [1:0] {
    GRAN_PAGE = 2'd0,
    GRAN_256  = 2'd1,
    GRAN_512  = 2'd2,
    GRAN_RSVD = 2'd3
  } nha_gran_e;

  localparam logic [7:0] OP_READ = 8'h00;
  localparam logic [7:0] OP_PROG = 8'h80;

endpackage

// File: rtl/nha_ctrl.sv
module nha_ctrl
  import nha_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmd_stb,
  input  logic              addr_stb,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              main_end_i,
  output logic              start_clr_o,
  output logic              acc_en_o,
  output logic              valid_o
);

  nha_state_e state_q, state_d;
  logic       valid_q, valid_d;
  logic       is_start_op;

  always_comb begin
    is_start_op = (bus_data[7:0] == OP_READ) || (bus_data[7:0] == OP_PROG);
  end

  always_comb begin
    acc_en_o = data_stb && !cmd_stb && !addr_stb && !clr && (state_q == ST_ACC);
  end

  always_comb begin
    state_d     = state_q;
    valid_d     = valid_q;
    start_clr_o = 1'b0;
    if (clr) begin
      state_d = ST_IDLE;
      valid_d = 1'b0;
    end else if (cmd_stb) begin
      if (is_start_op) begin
        state_d = ST_CMD;
      end else if (state_q == ST_CMD) begin
        state_d = ST_IDLE;
      end
    end else if (addr_stb && (state_q == ST_CMD)) begin
      state_d     = ST_ACC;
      valid_d     = 1'b0;
      start_clr_o = 1'b1;
    end else if (acc_en_o && main_end_i) begin
      state_d = ST_LOCK;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  AST_LOCK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |-> valid_q); // R7

  AST_ACC_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC) |-> !valid_q); // R2

endmodule

// File: rtl/nha_counter.sv
module nha_counter
  import nha_pkg::*;
#(
  parameter int MAIN_MIN_LOG2 = 9,
  parameter int PAGE_STEPS    = 4,
  parameter int SEC_MIN_LOG2  = 8,
  localparam int CFG_W        = $clog2(PAGE_STEPS),
  localparam int IDX_W        = MAIN_MIN_LOG2 + PAGE_STEPS - 1,
  localparam int NSLOT        = 1 << (IDX_W - SEC_MIN_LOG2),
  localparam int SLOT_IDX_W   = $clog2(NSLOT),
  localparam int CNT_SLOT_W   = SLOT_IDX_W + 1,
  localparam int LOG_W        = $clog2(IDX_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  step_i,
  input  logic [CFG_W-1:0]      page_cfg,
  input  logic [1:0]            gran_cfg,
  output logic [IDX_W-1:0]      local_idx_o,
  output logic [IDX_W-1:0]      line_en_o,
  output logic                  sector_end_o,
  output logic                  main_end_o,
  output logic [SLOT_IDX_W-1:0] slot_idx_o,
  output logic [CNT_SLOT_W-1:0] nused_o
);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [CFG_W-1:0] page_q, page_d;
  logic [1:0]       gran_q, gran_d;

  logic [LOG_W-1:0] main_log2;
  logic [LOG_W-1:0] sect_log2;
  logic [IDX_W-1:0] main_mask;
  logic [IDX_W-1:0] sect_mask;

  always_comb begin
    main_log2 = LOG_W'(MAIN_MIN_LOG2) + LOG_W'(page_q);
    case (gran_q)
      GRAN_256: sect_log2 = LOG_W'(SEC_MIN_LOG2);
      GRAN_512: sect_log2 = LOG_W'(SEC_MIN_LOG2 + 1);
      default:  sect_log2 = main_log2;
    endcase
    for (int k = 0; k < IDX_W; k++) begin
      main_mask[k] = (k < int'(main_log2));
      sect_mask[k] = (k < int'(sect_log2));
    end
  end

  always_comb begin
    local_idx_o  = cnt_q & sect_mask;
    line_en_o    = sect_mask;
    sector_end_o = ((cnt_q & sect_mask) == sect_mask);
    main_end_o   = (cnt_q == main_mask);
    slot_idx_o   = SLOT_IDX_W'(cnt_q >> sect_log2);
    nused_o      = CNT_SLOT_W'(1) << (main_log2 - sect_log2);
  end

  always_comb begin
    cnt_d  = cnt_q;
    page_d = page_q;
    gran_d = gran_q;
    if (start_i) begin
      cnt_d  = '0;
      page_d = page_cfg;
      gran_d = gran_cfg;
    end else if (step_i && !main_end_o) begin
      cnt_d = cnt_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      page_q <= '0;
      gran_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      page_q <= page_d;
      gran_q <= gran_d;
    end
  end

  AST_CNT_IN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q & ~main_mask) == '0); // R6

  AST_SECTOR_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    sect_log2 <= main_log2); // R5

endmodule

// File: rtl/nha_parity_acc.sv
module nha_parity_acc #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 12,
  localparam int COL_PAIRS = $clog2(DATA_W),
  localparam int COL_W     = 2 * COL_PAIRS,
  localparam int SLOT_W    = COL_W + 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              sector_end_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  local_idx_i,
  input  logic [IDX_W-1:0]  line_en_i,
  output logic [SLOT_W-1:0] acc_next_o
);

  logic [SLOT_W-1:0] acc_q, acc_d;
  logic [COL_W-1:0]  col_flip;
  logic [2*IDX_W-1:0] line_flip;
  logic              byte_par;
  logic [SLOT_W-1:0] used_mask;

  always_comb begin
    col_flip = '0;
    for (int j = 0; j < COL_PAIRS; j++) begin
      for (int p = 0; p < DATA_W; p++) begin
        if (((p >> j) & 1) == 1) col_flip[2*j+1] = col_flip[2*j+1] ^ data_i[p];
        else                     col_flip[2*j]   = col_flip[2*j]   ^ data_i[p];
      end
    end
  end

  always_comb begin
    byte_par = ^data_i;
    for (int k = 0; k < IDX_W; k++) begin
      line_flip[2*k]   = byte_par & line_en_i[k] & ~local_idx_i[k];
      line_flip[2*k+1] = byte_par & line_en_i[k] &  local_idx_i[k];
    end
  end

  always_comb begin
    acc_next_o = acc_q ^ {line_flip, col_flip};
  end

  always_comb begin
    acc_d = acc_q;
    if (clear_i) begin
      acc_d = '0;
    end else if (step_i) begin
      acc_d = sector_end_i ? '0 : acc_next_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_comb begin
    used_mask = '0;
    used_mask[COL_W-1:0] = '1;
    for (int k = 0; k < IDX_W; k++) begin
      used_mask[COL_W+2*k]   = line_en_i[k];
      used_mask[COL_W+2*k+1] = line_en_i[k];
    end
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && sector_end_i && !clear_i) |=> (acc_q == '0)); // R5

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q & ~used_mask) == '0); // R4

endmodule

// File: rtl/nha_slot_bank.sv
module nha_slot_bank #(
  parameter int SLOT_W = 30,
  parameter int NSLOT  = 16,
  localparam int SLOT_IDX_W = $clog2(NSLOT),
  localparam int CNT_SLOT_W = SLOT_IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    we_i,
  input  logic [SLOT_IDX_W-1:0]   widx_i,
  input  logic [SLOT_W-1:0]       wdata_i,
  input  logic [CNT_SLOT_W-1:0]   nused_i,
  output logic [NSLOT*SLOT_W-1:0] slots_o
);

  logic [NSLOT-1:0] slot_we;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [SLOT_W-1:0] slot_q, slot_d;

    always_comb begin
      slot_we[g] = we_i && (widx_i == SLOT_IDX_W'(g));
      slot_d     = slot_q;
      if (clear_i)         slot_d = '0;
      else if (slot_we[g]) slot_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign slots_o[g*SLOT_W +: SLOT_W] = slot_q;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_SLOT_W'(g) >= nused_i) |-> (slot_q == '0)); // R9
  end

  AST_WIDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> ({1'b0, widx_i} < nused_i)); // R5

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)); // R5

endmodule

// File: rtl/nand_hamming_acc.sv
module nand_hamming_acc #(
  parameter int DATA_W        = 8,
  parameter int MAIN_MIN_LOG2 = 9,
  parameter int PAGE_STEPS    = 4,
  parameter int SEC_MIN_LOG2  = 8,
  localparam int IDX_W        = MAIN_MIN_LOG2 + PAGE_STEPS - 1,
  localparam int NSLOT        = 1 << (IDX_W - SEC_MIN_LOG2),
  localparam int SLOT_IDX_W   = $clog2(NSLOT),
  localparam int CNT_SLOT_W   = SLOT_IDX_W + 1,
  localparam int SLOT_W       = 2 * $clog2(DATA_W) + 2 * IDX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            cmd_stb,
  input  logic                            addr_stb,
  input  logic                            data_stb,
  input  logic [DATA_W-1:0]               bus_data,
  input  logic [$clog2(PAGE_STEPS)-1:0]   page_cfg,
  input  logic [1:0]                      gran_cfg,
  output logic [NSLOT*SLOT_W-1:0]         parity_flat,
  output logic                            parity_valid
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                  start_clr;
  logic                  acc_en;
  logic                  main_end;
  logic                  sector_end;
  logic [IDX_W-1:0]      local_idx;
  logic [IDX_W-1:0]      line_en;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [CNT_SLOT_W-1:0] nused;
  logic [SLOT_W-1:0]     acc_next;
  logic                  wipe;

  assign wipe = start_clr | clr;

  nha_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr         (clr),
    .cmd_stb     (cmd_stb),
    .addr_stb    (addr_stb),
    .data_stb    (data_stb),
    .bus_data    (bus_data),
    .main_end_i  (main_end),
    .start_clr_o (start_clr),
    .acc_en_o    (acc_en),
    .valid_o     (parity_valid)
  );

  nha_counter #(
    .MAIN_MIN_LOG2 (MAIN_MIN_LOG2),
    .PAGE_STEPS    (PAGE_STEPS),
    .SEC_MIN_LOG2  (SEC_MIN_LOG2)
  ) u_counter (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_clr),
    .step_i       (acc_en),
    .page_cfg     (page_cfg),
    .gran_cfg     (gran_cfg),
    .local_idx_o  (local_idx),
    .line_en_o    (line_en),
    .sector_end_o (sector_end),
    .main_end_o   (main_end),
    .slot_idx_o   (slot_idx),
    .nused_o      (nused)
  );

  nha_parity_acc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_acc (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clear_i      (wipe),
    .step_i       (acc_en),
    .sector_end_i (sector_end),
    .data_i       (bus_data),
    .local_idx_i  (local_idx),
    .line_en_i    (line_en),
    .acc_next_o   (acc_next)
  );

  nha_slot_bank #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (wipe),
    .we_i    (acc_en && sector_end),
    .widx_i  (slot_idx),
    .wdata_i (acc_next),
    .nused_i (nused),
    .slots_o (parity_flat)
  );

  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (parity_valid && !start_clr && !clr) |=> $stable(parity_flat)); // R8

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (!parity_valid && (parity_flat == '0))); // R10

  AST_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_clr |=> (!parity_valid && (parity_flat == '0))); // R2

  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_en && main_end) |=> parity_valid); // R7

endmodule

// File: tb/test_nand_hamming_acc.sv
module test_nand_hamming_acc;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W     = 30;
  localparam int NSLOT      = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                    rst_n, clr, cmd_stb, addr_stb, data_stb;
  logic [7:0]              bus_data;
  logic [1:0]              page_cfg, gran_cfg;
  logic [NSLOT*SLOT_W-1:0] parity_flat;
  logic                    parity_valid;

  nand_hamming_acc i_nand_hamming_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .cmd_stb      (cmd_stb),
    .addr_stb     (addr_stb),
    .data_stb     (data_stb),
    .bus_data     (bus_data),
    .page_cfg     (page_cfg),
    .gran_cfg     (gran_cfg),
    .parity_flat  (parity_flat),
    .parity_valid (parity_valid)
  );

  int checks   = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    int v;
    v = i * 29 + seed * 53 + (i >> 5) * 7;
    return 8'(v) ^ 8'((i >> 8) * 3 + seed);
  endfunction

  function automatic int sect_log2(input int page, input int gran);
    if (gran == 1) return 8;
    if (gran == 2) return 9;
    return 9 + page;
  endfunction

  function automatic logic [SLOT_W-1:0] exp_slot(input int slot, input int page,
                                                 input int gran, input int seed);
    logic [SLOT_W-1:0] r;
    logic [7:0] d;
    int nb, first, li;
    r     = '0;
    nb    = sect_log2(page, gran);
    first = slot << nb;
    if (first < (512 << page)) begin
      for (int i = first; i < first + (1 << nb); i++) begin
        d  = pat(i, seed);
        li = i - first;
        for (int p = 0; p < 8; p++)
          if (d[p])
            for (int j = 0; j < 3; j++) r[2*j + ((p >> j) & 1)] ^= 1'b1;
        if (^d)
          for (int k = 0; k < nb; k++) r[6 + 2*k + ((li >> k) & 1)] ^= 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] get_slot(input int k);
    return parity_flat[k*SLOT_W +: SLOT_W];
  endfunction

  task automatic pulse_cmd(input logic [7:0] b);
    @(negedge clk); cmd_stb = 1'b1; bus_data = b;
    @(negedge clk); cmd_stb = 1'b0;
  endtask

  task automatic addr_cycles(input int n);
    for (int a = 0; a < n; a++) begin
      @(negedge clk); addr_stb = 1'b1; bus_data = 8'(a + 8'h21);
    end
    @(negedge clk); addr_stb = 1'b0;
  endtask

  task automatic send_bytes(input int n, input int seed, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_stb = 1'b1; bus_data = pat(base + i, seed);
    end
    @(negedge clk); data_stb = 1'b0;
  endtask

  task automatic check_all_slots(input int page, input int gran, input int seed,
                                 input string req);
    for (int k = 0; k < NSLOT; k++)
      check(get_slot(k) == exp_slot(k, page, gran, seed), req,
            $sformatf("slot %0d page %0d gran %0d", k, page, gran),
            64'(get_slot(k)), 64'(exp_slot(k, page, gran, seed)));
  endtask

  task automatic run_config(input int page, input int gran, input int seed,
                            input logic [7:0] op);
    int main;
    logic [NSLOT*SLOT_W-1:0] snap;
    main     = 512 << page;
    page_cfg = 2'(page);
    gran_cfg = 2'(gran);
    pulse_cmd(op);
    addr_cycles(4);
    check(parity_valid == 1'b0 && parity_flat == '0, "R2", "cleared after start",
          64'(parity_valid), 64'(0));
    send_bytes(main - 1, seed, 0);
    check(parity_valid == 1'b0, "R7", "valid before last byte", 64'(parity_valid), 64'(0));
    send_bytes(1, seed, main - 1);
    check(parity_valid == 1'b1, "R7", "valid after last byte", 64'(parity_valid), 64'(1));
    check_all_slots(page, gran, seed, "R3 R4 R5 R6 R9");
    snap = parity_flat;
    send_bytes(16, seed + 1, main);
    check(parity_flat == snap && parity_valid, "R8", "spare bytes ignored",
          64'(parity_flat == snap), 64'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [SLOT_W-1:0] s0;
    rst_n = 1'b0; clr = 1'b0; cmd_stb = 1'b0; addr_stb = 1'b0; data_stb = 1'b0;
    bus_data = 8'h00; page_cfg = 2'd0; gran_cfg = 2'd0;
    repeat (4) @(negedge clk);
    check(parity_valid == 1'b0 && parity_flat == '0, "R1", "during reset",
          64'(parity_valid), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(parity_valid == 1'b0 && parity_flat == '0, "R1", "after reset",
          64'(parity_valid), 64'(0));

    for (int pg = 0; pg < 4; pg++)
      for (int gr = 0; gr < 3; gr++)
        run_config(pg, gr, pg * 3 + gr + 1, ((pg + gr) % 2 == 0) ? 8'h00 : 8'h80);

    // reserved granularity code 3 behaves as whole page
    run_config(1, 3, 77, 8'h00);

    // R2: non-start command with address clears nothing
    s0 = get_slot(0);
    pulse_cmd(8'h70);
    addr_cycles(3);
    send_bytes(5, 9, 0);
    check(parity_valid == 1'b1 && get_slot(0) == s0, "R2", "other command ignored",
          64'(get_slot(0)), 64'(s0));

    // R8: start command without address leaves results locked
    pulse_cmd(8'h00);
    send_bytes(3, 9, 0);
    check(parity_valid == 1'b1 && get_slot(0) == s0, "R8", "start byte without address",
          64'(get_slot(0)), 64'(s0));
    addr_cycles(1);
    check(parity_valid == 1'b0 && parity_flat == '0, "R2", "address completes start",
          64'(parity_valid), 64'(0));

    // R11: configuration changed mid page is ignored
    page_cfg = 2'd0; gran_cfg = 2'd1;
    pulse_cmd(8'h80);
    addr_cycles(2);
    page_cfg = 2'd3; gran_cfg = 2'd0;
    send_bytes(512, 41, 0);
    check(parity_valid == 1'b1, "R11", "valid at sampled page end", 64'(parity_valid), 64'(1));
    check_all_slots(0, 1, 41, "R11");

    // R10: synchronous clear mid page
    page_cfg = 2'd0; gran_cfg = 2'd0;
    pulse_cmd(8'h00);
    addr_cycles(2);
    send_bytes(100, 5, 0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(parity_valid == 1'b0 && parity_flat == '0, "R10", "clear empties",
          64'(parity_valid), 64'(0));
    send_bytes(412, 5, 100);
    check(parity_valid == 1'b0 && parity_flat == '0, "R10", "data ignored after clear",
          64'(get_slot(0)), 64'(0));

    // R10: clear after lock
    run_config(0, 2, 63, 8'h80);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(parity_valid == 1'b0 && parity_flat == '0, "R10", "clear after lock",
          64'(parity_valid), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule